// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

This block forms a Montgomery product of two multi-word operands. With K-bit words and N words per operand it returns a value congruent to A·B·2^(−K·N) modulo an odd modulus M. Operand A is consumed one K-bit word per clock cycle. Each step adds a word product a_i·B and a quotient multiple q·M into a carry-save accumulator, then shifts it down by one word. The quotient digit q comes from the low word of the registered accumulator, and the new a_i·B term enters after that shift. This keeps the quotient off the path through the current word product, so one quotient digit is ready every cycle.

Operands need not be fully reduced. Any value below 8M is accepted, provided 2^(K·N) ≥ 64·M (that is, M < 2^(K·N−6)). Under that condition the Montgomery step alone keeps the result below 2M, which is a valid input to the next multiplication. No final subtraction is done. Before use, the modulus and the word constant −M^(−1) mod 2^K are written through a configuration port. A start pulse launches one product. A one-cycle done pulse presents the carry-resolved result, which is then held.

The control is a three-state machine. In ST_IDLE the configuration can be written, and start takes the transition GO to ST_ITER while loading the operands and clearing the accumulator. ST_ITER runs N+1 word steps (the last with a zero word) and takes the transition LAST to ST_RESOLVE. ST_RESOLVE adds the two redundant vectors, registers the result, raises done and takes FINISH back to ST_IDLE.

Top module: `mont_mul`

## Requirements
- R1: After reset, busy, done and res are all 0.
- R2: For odd M < 2^(K·N−6) and operands A, B < 8M, the result satisfies res·2^(K·N) ≡ A·B (mod M).
- R3: The result always satisfies res < 2M.
- R4: done rises exactly N+2 clock cycles after the edge that samples start in the idle state. busy is high from the cycle after that edge until done rises, and it falls in the same cycle that done rises.
- R5: done is high for exactly one cycle, and res holds its value until the next done.
- R6: start while busy is ignored: the running product, its timing and its result are unchanged, and no second product follows.
- R7: A configuration write (cfg_we with cfg_mod = M and cfg_minv = −M^(−1) mod 2^K) takes effect only in the idle state. A write while busy is discarded, and later products still use the old constants.
- R8: A start in the cycle where done is high is accepted, and that product completes with the latency of R4.
- R9: A zero operand yields res = 0, and the largest operands A = B = 8M−1 still meet R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write the modulus and the word constant (idle only) |
| cfg_mod | input | K·N | Odd modulus M |
| cfg_minv | input | K | −M^(−1) mod 2^K |
| start | input | 1 | Launch a product (taken in idle only) |
| op_a | input | K·N | Multiplier operand A, below 8M |
| op_b | input | K·N | Multiplicand operand B, below 8M |
| busy | output | 1 | A product is in progress |
| done | output | 1 | One-cycle pulse: res is valid |
| res | output | K·N | Carry-resolved Montgomery product |

## Verification
The bound assertion assumes that the loaded constants are consistent: M is odd, M < 2^(K·N−6), cfg_minv really is −M^(−1) mod 2^K, and both operands lie below 8M. The latency and pulse checks assume only that start is sampled on clock edges. The bench draws each modulus with its top allowed bit set and bit 0 forced to 1, computes the constant by Newton iteration, and reduces every random operand modulo 8M. It then checks congruence and bound with a 256-bit integer model rather than a copy of the datapath.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ITER    = 2'd1,
        ST_RESOLVE = 2'd2
    } mm_state_t;

endpackage

// File: rtl/mm_quot.sv
// Quotient digit: low word of the redundant accumulator times -M^-1 mod 2^K.
module mm_quot #(
    parameter int K = 16
) (
    input  logic [K-1:0] s_lo,
    input  logic [K-1:0] c_lo,
    input  logic         cin,
    input  logic [K-1:0] minv,
    output logic [K-1:0] q
);
    logic [K-1:0] low_word;

    // three-operand add of one word, truncated to the word
    assign low_word = s_lo + c_lo + K'(cin);
    assign q        = low_word * minv;
endmodule

// File: rtl/mm_csa.sv
// Bitwise 3:2 compressor; cin fills the free bit 0 of the carry vector.
module mm_csa #(
    parameter int WD = 8
) (
    input  logic [WD-1:0] x,
    input  logic [WD-1:0] y,
    input  logic [WD-1:0] z,
    input  logic          cin,
    output logic [WD-1:0] s,
    output logic [WD-1:0] co
);
    logic [WD-2:0] maj;

    assign s = x ^ y ^ z;

    genvar gi;
    generate
        for (gi = 0; gi < WD - 1; gi++) begin : g_maj
            assign maj[gi] = (x[gi] & y[gi]) | (x[gi] & z[gi]) | (y[gi] & z[gi]);
        end
    endgenerate

    assign co = {maj, cin};
endmodule

// File: rtl/mm_cpa.sv
// Final carry-propagate adder of the two redundant vectors plus carry bit.
module mm_cpa #(
    parameter int OW = 64
) (
    input  logic [OW-1:0] s,
    input  logic [OW-1:0] c,
    input  logic          cin,
    output logic [OW-1:0] sum
);
    assign sum = s + c + OW'(cin);
endmodule

// File: rtl/mont_mul.sv
module mont_mul
    import mm_pkg::*;
#(
    parameter int K = 16,
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [K*N-1:0]   cfg_mod,
    input  logic [K-1:0]     cfg_minv,
    input  logic             start,
    input  logic [K*N-1:0]   op_a,
    input  logic [K*N-1:0]   op_b,
    output logic             busy,
    output logic             done,
    output logic [K*N-1:0]   res
);
    localparam int W  = K * N;
    localparam int SW = W + 2 * K + 2;
    localparam int IW = $clog2(N + 1);

    mm_state_t st_q, st_d;

    logic [W-1:0]  mod_q;
    logic [K-1:0]  minv_q;
    logic [W-1:0]  a_q;
    logic [W-1:0]  b_q;
    logic [SW-1:0] ps_q;
    logic [SW-1:0] pc_q;
    logic          cb_q;
    logic [IW-1:0] idx_q;
    logic          done_q;
    logic [W-1:0]  res_q;

    // ---------------- datapath ----------------
    logic [K-1:0]   qd;
    logic [W+K-1:0] qm;
    logic [W+K-1:0] ab;
    logic [SW-1:0]  qm_ext;
    logic [SW-1:0]  ab_ext;
    logic [SW-1:0]  s1, c1, s2, c2;
    logic [SW-1:0]  ps_n, pc_n;
    logic           cb_n;
    logic [W-1:0]   res_full;

    mm_quot #(.K(K)) u_quot (
        .s_lo (ps_q[K-1:0]),
        .c_lo (pc_q[K-1:0]),
        .cin  (cb_q),
        .minv (minv_q),
        .q    (qd)
    );

    assign qm     = (W + K)'(qd) * (W + K)'(mod_q);
    assign ab     = (W + K)'(a_q[K-1:0]) * (W + K)'(b_q);
    assign qm_ext = {{(SW - W - K){1'b0}}, qm};
    assign ab_ext = {{(SW - W - 2 * K){1'b0}}, ab, {K{1'b0}}};

    mm_csa #(.WD(SW)) u_csa_q (
        .x   (ps_q),
        .y   (pc_q),
        .z   (qm_ext),
        .cin (cb_q),
        .s   (s1),
        .co  (c1)
    );

    mm_csa #(.WD(SW)) u_csa_ab (
        .x   (s1),
        .y   (c1),
        .z   (ab_ext),
        .cin (1'b0),
        .s   (s2),
        .co  (c2)
    );

    // low words of s2 and c2 sum to 0 or 2^K; that carry moves to cb
    assign ps_n = s2 >> K;
    assign pc_n = c2 >> K;
    assign cb_n = (|s2[K-1:0]) | (|c2[K-1:0]);

    mm_cpa #(.OW(W)) u_cpa (
        .s   (ps_q[W-1:0]),
        .c   (pc_q[W-1:0]),
        .cin (cb_q),
        .sum (res_full)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start) st_d = ST_ITER;                  // GO
            ST_ITER:    if (idx_q == IW'(N)) st_d = ST_RESOLVE;     // LAST
            ST_RESOLVE: st_d = ST_IDLE;                             // FINISH
            default:    st_d = ST_IDLE;
        endcase
    end

    // ---------------- registered datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q  <= '0;
            minv_q <= '0;
            a_q    <= '0;
            b_q    <= '0;
            ps_q   <= '0;
            pc_q   <= '0;
            cb_q   <= 1'b0;
            idx_q  <= '0;
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= (st_q == ST_RESOLVE);
            unique case (st_q)
                ST_IDLE: begin
                    if (cfg_we) begin
                        mod_q  <= cfg_mod;
                        minv_q <= cfg_minv;
                    end
                    if (start) begin
                        a_q   <= op_a;
                        b_q   <= op_b;
                        ps_q  <= '0;
                        pc_q  <= '0;
                        cb_q  <= 1'b0;
                        idx_q <= '0;
                    end
                end
                ST_ITER: begin
                    ps_q  <= ps_n;
                    pc_q  <= pc_n;
                    cb_q  <= cb_n;
                    a_q   <= a_q >> K;
                    idx_q <= idx_q + 1'b1;
                end
                ST_RESOLVE: begin
                    res_q <= res_full;
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy = (st_q != ST_IDLE);
        done = done_q;
        res  = res_q;
    end

endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
    parameter int K = 16,
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [K*N-1:0] res,
    input logic [K*N-1:0] mod_q
);
    logic [7:0] lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat <= '0;
        end else if (start && !busy) begin
            lat <= 8'd1;
        end else if (busy) begin
            lat <= lat + 8'd1;
        end
    end

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat == 8'(N + 3)));

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({1'b0, res} < {mod_q, 1'b0}));

    // R6
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind mont_mul mont_mul_chk #(.K(K), .N(N)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .res   (res),
    .mod_q (mod_q)
);

// File: tb/mont_mul_bench.sv
module mont_mul_bench;
    localparam int K = 16;
    localparam int N = 4;
    localparam int W = K * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [W-1:0] cfg_mod = '0;
    logic [K-1:0] cfg_minv = '0;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] res;

    int total = 0;
    int bad = 0;
    logic [W-1:0] cur_m;

    always #2 clk = ~clk;

    mont_mul #(.K(K), .N(N)) u_mont_mul (
        .clk, .rst_n, .cfg_we, .cfg_mod, .cfg_minv,
        .start, .op_a, .op_b, .busy, .done, .res
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [K-1:0] neg_inv(input logic [W-1:0] m);
        logic [K-1:0] x;
        x = m[K-1:0];
        for (int i = 0; i < 5; i++) x = x * (K'(2) - m[K-1:0] * x);
        return -x;
    endfunction

    function automatic logic [W-1:0] rand_mod();
        logic [W-1:0] m;
        m = {$urandom, $urandom};
        m[W-1:W-6] = '0;
        m[W-7] = 1'b1;
        m[0] = 1'b1;
        return m;
    endfunction

    function automatic logic [W-1:0] rand_op(input logic [W-1:0] m);
        logic [W+3:0] lim;
        logic [W+3:0] v;
        lim = {m, 3'b000};
        v = (W + 4)'({$urandom, $urandom});
        return W'(v % lim);
    endfunction

    task automatic check_result(input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic [W-1:0] m, input logic [W-1:0] r, input string tag);
        logic [255:0] lhs, rhs, mm;
        mm  = 256'(m);
        lhs = ((256'(r)) << W) % mm;
        rhs = (256'(a) * 256'(b)) % mm;
        chk(lhs == rhs, {"R2 congruence ", tag}, lhs, rhs);
        chk(256'(r) < (mm << 1), {"R3 bound ", tag}, 256'(r), mm << 1);
    endtask

    task automatic load_cfg(input logic [W-1:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mod = m; cfg_minv = neg_inv(m);
        @(negedge clk);
        cfg_we = 1'b0;
        cur_m = m;
    endtask

    // mode 0 plain, 1 start pulse mid-run, 2 config write mid-run
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input int mode,
                          output logic [W-1:0] r, output int cyc);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        chk(busy == 1'b1, "R4 busy after start", 256'(busy), 256'(1));
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (cyc == 2 && mode == 1) begin
                op_a = ~a; op_b = ~b; start = 1'b1;
            end else if (cyc == 2 && mode == 2) begin
                cfg_we = 1'b1; cfg_mod = rand_mod(); cfg_minv = ~cfg_minv;
            end else begin
                start = 1'b0; cfg_we = 1'b0;
            end
            if (!done) chk(busy == 1'b1, "R4 busy during run", 256'(busy), 256'(1));
        end
        start = 1'b0; cfg_we = 1'b0;
        r = res;
        chk(busy == 1'b0, "R4 busy falls with done", 256'(busy), 256'(0));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy", 256'(busy), 256'(0));
        chk(done == 1'b0, "R1 done", 256'(done), 256'(0));
        chk(res == '0, "R1 res", 256'(res), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic();
        logic [W-1:0] r, held;
        int cyc;
        load_cfg(rand_mod());
        run_op(W'(3), W'(5), 0, r, cyc);
        chk(cyc == N + 2, "R4 latency", 256'(cyc), 256'(N + 2));
        check_result(W'(3), W'(5), cur_m, r, "small");
        @(negedge clk);
        chk(done == 1'b0, "R5 done one cycle", 256'(done), 256'(0));
        held = res;
        repeat (4) @(negedge clk);
        chk(res == held && res == r, "R5 res held", 256'(res), 256'(r));
    endtask

    task automatic t_random();
        logic [W-1:0] a, b, r;
        int cyc;
        for (int mi = 0; mi < 4; mi++) begin
            load_cfg(rand_mod());
            for (int i = 0; i < 10; i++) begin
                a = rand_op(cur_m);
                b = rand_op(cur_m);
                run_op(a, b, 0, r, cyc);
                check_result(a, b, cur_m, r, "random");
                chk(cyc == N + 2, "R4 latency random", 256'(cyc), 256'(N + 2));
            end
        end
    endtask

    task automatic t_boundary();
        logic [W-1:0] r, mx;
        int cyc;
        load_cfg(rand_mod());
        run_op('0, rand_op(cur_m), 0, r, cyc);
        chk(r == '0, "R9 zero A", 256'(r), 256'(0));
        run_op(rand_op(cur_m), '0, 0, r, cyc);
        chk(r == '0, "R9 zero B", 256'(r), 256'(0));
        mx = (cur_m << 3) - W'(1);
        run_op(mx, mx, 0, r, cyc);
        check_result(mx, mx, cur_m, r, "R9 max");
    endtask

    task automatic t_ignore_start();
        logic [W-1:0] a, b, r;
        int cyc;
        a = rand_op(cur_m); b = rand_op(cur_m);
        run_op(a, b, 1, r, cyc);
        chk(cyc == N + 2, "R6 latency kept", 256'(cyc), 256'(N + 2));
        check_result(a, b, cur_m, r, "R6 result kept");
        @(negedge clk);
        chk(busy == 1'b0, "R6 no restart", 256'(busy), 256'(0));
    endtask

    task automatic t_cfg_busy();
        logic [W-1:0] a, b, r;
        int cyc;
        a = rand_op(cur_m); b = rand_op(cur_m);
        run_op(a, b, 2, r, cyc);
        check_result(a, b, cur_m, r, "R7 during write");
        a = rand_op(cur_m); b = rand_op(cur_m);
        run_op(a, b, 0, r, cyc);
        check_result(a, b, cur_m, r, "R7 old config kept");
    endtask

    task automatic t_back2back();
        logic [W-1:0] a1, b1, a2, b2, r1, r2;
        int cyc;
        a1 = rand_op(cur_m); b1 = rand_op(cur_m);
        a2 = rand_op(cur_m); b2 = rand_op(cur_m);
        run_op(a1, b1, 0, r1, cyc);
        // done is high now: launch the next product in this cycle
        op_a = a2; op_b = b2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 accepted on done", 256'(busy), 256'(1));
        cyc = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        r2 = res;
        chk(cyc == N + 2, "R8 latency", 256'(cyc), 256'(N + 2));
        check_result(a1, b1, cur_m, r1, "R8 first");
        check_result(a2, b2, cur_m, r2, "R8 second");
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cur_m = '0;
        t_reset();
        t_basic();
        t_random();
        t_boundary();
        t_ignore_start();
        t_cfg_busy();
        t_back2back();
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule